// File: doc/BRIEF.md
# Sticky Lock-Down Control Register

This block holds a 32-bit word of write-once lock bits. Each bit, once software sets it, freezes a group of configuration registers further down the chip. A global lock-down input can also freeze every group at once. The block adds the global lock to each stored bit with an OR and drives the result on per-group effective-lock outputs. Downstream registers use those outputs to refuse writes.

The lock bits belong to two reset domains. The five protected-range lock bits return to 0 only on the firmware-partition reset. All other implemented bits return to 0 only on the host-partition reset.

A small set of example protected registers sits inside the block to show how the gating works. There are five range registers under the range locks and one sequencing register under the sequencing lock.

Top module: `lockdown_reg`

## Requirements
- R1: After either reset, every implemented lock bit, every effective-lock output and every example protected register reads 0.
- R2: Bits 31:17 of the read value are always 0, and writes to those positions have no effect.
- R3: Each effective-lock output is high when its stored bit is set or when global_lock is high. The outputs are seq_lock (bit 16), range_lock[4:0] (bits 12:8) and grant_lock[3:0] (bits 3:0).
- R4: A lock bit that is set stays set when a 0 is written to it. Software cannot clear it.
- R5: With global_lock low, a write sets exactly the implemented bits written as 1, and the read value shows this on the next cycle. Bits written as 0 stay 0. Bits 16, 15:13, 12:8, 7:4 and 3:0 are implemented.
- R6: While global_lock is high, a write leaves every lock bit unchanged.
- R7: Asserting fw_rst_n low on its own clears bits 12:8 and the range registers, and leaves the other bits and the sequencing register unchanged.
- R8: Asserting host_rst_n low on its own clears bits 16, 15:13, 7:4 and 3:0 and the sequencing register, and leaves bits 12:8 and the range registers unchanged.
- R9: A write to a protected register is taken in the next cycle if its effective lock is low, and rejected if the lock is high in the cycle of the write. pw_sel 0 to 4 select range registers 0 to 4 (range_lock[0] to [4]). pw_sel 5 selects the sequencing register (seq_lock). pw_sel 6 and 7 select nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| host_rst_n | input | 1 | Host-partition reset, asynchronous, active low |
| fw_rst_n | input | 1 | Firmware-partition reset, asynchronous, active low |
| global_lock | input | 1 | Global lock-down |
| wr_en | input | 1 | Lock register write strobe |
| wr_data | input | 32 | Lock register write data |
| rd_data | output | 32 | Lock register read value |
| seq_lock | output | 1 | Effective lock of the sequencing group |
| range_lock | output | 5 | Effective locks of the five range registers |
| grant_lock | output | 4 | Effective locks of the four access-grant groups |
| pw_en | input | 1 | Protected register write strobe |
| pw_sel | input | 3 | Protected register select |
| pw_data | input | PW | Protected register write data |
| range_q | output | 5*PW | Range register contents, register k at [k*PW +: PW] |
| seq_q | output | PW | Sequencing register contents |

## Verification
The assertions check four rules on every cycle:
- no stored bit ever falls from 1 to 0 outside a reset;
- a write with the global lock low sets every implemented bit written as 1;
- the global lock freezes the whole word;
- a protected register never changes after a write made while its lock is high.

Only the bench scenarios can show the rest:
- which bits each reset domain clears, since each reset is pulsed alone and the other domain's bits are checked as unchanged;
- the zero reads of the reserved positions;
- the reset values;
- that an unlocked protected register actually takes the written data.

// File: rtl/lockdown_reg.sv
module lockdown_reg #(
  parameter int PW = 16
) (
  input  logic            clk,
  input  logic            host_rst_n,
  input  logic            fw_rst_n,
  input  logic            global_lock,
  input  logic            wr_en,
  input  logic [31:0]     wr_data,
  output logic [31:0]     rd_data,
  output logic            seq_lock,
  output logic [4:0]      range_lock,
  output logic [3:0]      grant_lock,
  input  logic            pw_en,
  input  logic [2:0]      pw_sel,
  input  logic [PW-1:0]   pw_data,
  output logic [5*PW-1:0] range_q,
  output logic [PW-1:0]   seq_q
);

  localparam logic [31:0] FW_BITS   = 32'h0000_1F00;
  localparam logic [31:0] HOST_BITS = 32'h0001_E0FF;
  localparam logic [31:0] IMPL_BITS = FW_BITS | HOST_BITS;

  logic [31:0] fw_q, host_q, set_req;
  logic [7:0]  lock_by_sel;

  assign set_req = (wr_en && !global_lock) ? wr_data : 32'd0;

  always_ff @(posedge clk or negedge fw_rst_n)
    if (!fw_rst_n) fw_q <= '0;
    else           fw_q <= (fw_q | set_req) & FW_BITS;

  always_ff @(posedge clk or negedge host_rst_n)
    if (!host_rst_n) host_q <= '0;
    else             host_q <= (host_q | set_req) & HOST_BITS;

  assign rd_data    = fw_q | host_q;
  assign seq_lock   = rd_data[16] | global_lock;
  assign range_lock = rd_data[12:8] | {5{global_lock}};
  assign grant_lock = rd_data[3:0] | {4{global_lock}};

  assign lock_by_sel = {2'b00, seq_lock, range_lock};

  for (genvar g = 0; g < 5; g++) begin : g_range
    always_ff @(posedge clk or negedge fw_rst_n)
      if (!fw_rst_n)
        range_q[g*PW +: PW] <= '0;
      else if (pw_en && pw_sel == 3'(g) && !lock_by_sel[g])
        range_q[g*PW +: PW] <= pw_data;
  end

  always_ff @(posedge clk or negedge host_rst_n)
    if (!host_rst_n)
      seq_q <= '0;
    else if (pw_en && pw_sel == 3'd5 && !lock_by_sel[5])
      seq_q <= pw_data;

  assert_sticky_R4: assert property (@(posedge clk) disable iff (!host_rst_n || !fw_rst_n)
    1'b1 |=> (($past(rd_data) & ~rd_data) == 32'd0));

  assert_set_R5: assert property (@(posedge clk) disable iff (!host_rst_n || !fw_rst_n)
    (wr_en && !global_lock) |=>
      ((rd_data & $past(wr_data) & IMPL_BITS) == ($past(wr_data) & IMPL_BITS)));

  assert_freeze_R6: assert property (@(posedge clk) disable iff (!host_rst_n || !fw_rst_n)
    global_lock |=> (rd_data == $past(rd_data)));

  assert_reject_R9: assert property (@(posedge clk) disable iff (!host_rst_n || !fw_rst_n)
    (pw_en && lock_by_sel[pw_sel]) |=> ($stable(range_q) && $stable(seq_q)));

endmodule

// File: tb/lockdown_reg_tb.sv
`timescale 1ns/1ps
module lockdown_reg_tb;
  localparam int PW = 16;
  localparam logic [31:0] FW_BITS   = 32'h0000_1F00;
  localparam logic [31:0] HOST_BITS = 32'h0001_E0FF;
  localparam logic [31:0] IMPL      = FW_BITS | HOST_BITS;

  logic clk = 0, host_rst_n = 0, fw_rst_n = 0, global_lock = 0, wr_en = 0, pw_en = 0;
  logic [31:0] wr_data = 0;
  logic [2:0] pw_sel = 0;
  logic [PW-1:0] pw_data = 0;
  logic [31:0] rd_data;
  logic seq_lock;
  logic [4:0] range_lock;
  logic [3:0] grant_lock;
  logic [5*PW-1:0] range_q;
  logic [PW-1:0] seq_q;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lockdown_reg #(.PW(PW)) u_dut (
    .clk(clk), .host_rst_n(host_rst_n), .fw_rst_n(fw_rst_n), .global_lock(global_lock),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .seq_lock(seq_lock),
    .range_lock(range_lock), .grant_lock(grant_lock), .pw_en(pw_en), .pw_sel(pw_sel),
    .pw_data(pw_data), .range_q(range_q), .seq_q(seq_q));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = 0;
  endtask

  task automatic pw(input int s, input logic [PW-1:0] d);
    @(negedge clk); pw_en = 1; pw_sel = 3'(s); pw_data = d;
    @(negedge clk); pw_en = 0;
  endtask

  task automatic rst(input bit host, input bit fw);
    @(negedge clk); host_rst_n = !host; fw_rst_n = !fw;
    @(negedge clk); host_rst_n = 1; fw_rst_n = 1;
    @(negedge clk);
  endtask

  function automatic logic [31:0] eff(input logic [31:0] s, input logic g);
    return {22'd0, s[16] | g, s[12:8] | {5{g}}, s[3:0] | {4{g}}};
  endfunction

  function automatic logic [31:0] slice(input int k);
    return 32'(range_q[k*PW +: PW]);
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    host_rst_n = 1; fw_rst_n = 1;
    @(negedge clk);
    chk("R1 rd_data", rd_data, 32'd0);
    chk("R1 locks", {22'd0, seq_lock, range_lock, grant_lock}, 32'd0);
    chk("R1 range_q", 32'(|range_q), 32'd0);
    chk("R1 seq_q", 32'(seq_q), 32'd0);

    for (int i = 0; i < 32; i++) begin
      logic [31:0] e;
      e = (32'd1 << i) & IMPL;
      rst(1, 1);
      wr(32'd1 << i);
      chk("R5/R2 single bit", rd_data, e);
      chk("R3 effective", {22'd0, seq_lock, range_lock, grant_lock}, eff(e, 0));
      wr(32'd0);
      chk("R4 write zero", rd_data, e);
    end
    rst(1, 1);
    wr(32'hFFFF_FFFF);
    chk("R2 all ones", rd_data, IMPL);
    wr(32'h0000_0000);
    chk("R4 clear attempt", rd_data, IMPL);

    rst(1, 1);
    wr(32'h0000_0105);
    global_lock = 1;
    @(negedge clk);
    chk("R3 global", {22'd0, seq_lock, range_lock, grant_lock}, eff(32'h105, 1));
    wr(32'hFFFF_FFFF);
    chk("R6 frozen", rd_data, 32'h0000_0105);
    global_lock = 0;
    @(negedge clk);
    chk("R3 release", {22'd0, seq_lock, range_lock, grant_lock}, eff(32'h105, 0));
    wr(32'h0001_0000);
    chk("R5 after release", rd_data, 32'h0001_0105);

    rst(1, 1);
    pw(0, 16'h1111); pw(5, 16'h5555);
    wr(32'hFFFF_FFFF);
    rst(0, 1);
    chk("R7 fw reset alone", rd_data, HOST_BITS);
    chk("R7 range cleared", slice(0), 32'd0);
    chk("R7 seq kept", 32'(seq_q), 32'h5555);
    rst(1, 1);
    pw(0, 16'h2222); pw(5, 16'h6666);
    wr(32'hFFFF_FFFF);
    rst(1, 0);
    chk("R8 host reset alone", rd_data, FW_BITS);
    chk("R8 range kept", slice(0), 32'h2222);
    chk("R8 seq cleared", 32'(seq_q), 32'd0);

    for (int k = 0; k < 5; k++) begin
      rst(1, 1);
      pw(k, 16'hA000 + 16'(k));
      chk("R9 accepted", slice(k), 32'hA000 + 32'(k));
      wr(32'd1 << (8 + k));
      pw(k, 16'h5A5A);
      chk("R9 rejected", slice(k), 32'hA000 + 32'(k));
      pw((k + 1) % 5, 16'h0F00);
      chk("R9 neighbour open", slice((k + 1) % 5), 32'h0F00);
    end
    rst(1, 1);
    pw(5, 16'h1234);
    chk("R9 seq accepted", 32'(seq_q), 32'h1234);
    wr(32'h0001_0000);
    pw(5, 16'hFFFF);
    chk("R9 seq rejected", 32'(seq_q), 32'h1234);
    rst(1, 1);
    global_lock = 1;
    pw(2, 16'h7777);
    chk("R9 global rejects", slice(2), 32'd0);
    global_lock = 0;
    pw(6, 16'h9999);
    chk("R9 sel 6 ignored", 32'(|range_q) | 32'(|seq_q), 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule